// File: doc/BRIEF.md
# Dock Register Update Unit for Set and Shift Instructions

This unit carries out the two register-writing instructions of a dock: the set instruction, which loads one of the outer loop counter, the inner loop counter, the torpedo acknowledgment path latch, the data latch or the two user flags, and the shift instruction, which pushes a fixed-width literal into the low end of the data latch. The instruction arrives already decoded into a kind bit, a 2-bit source selector, a 3-bit destination selector and an immediate field. Predicate evaluation and instruction sequencing stay with the surrounding dock logic. That logic tells this unit when an instruction comes on deck and when it executes.

The work is split in time. On the on-deck strobe the unit decodes the instruction into an operation and captures the possibly-extended literal into a private literal latch. On the execute strobe it applies the staged operation to the architectural registers. A two-state machine tracks the staging. State IDLE holds nothing. Transition LOAD moves from IDLE to ARMED on an on-deck strobe. Transition FIRE returns from ARMED to IDLE on an execute strobe. Transition FIRE_LOAD stays in ARMED when both strobes come together: the old operation is applied and the new one is staged. Transition RELOAD stays in ARMED when an on-deck strobe comes alone and overwrites the staged operation. An execute strobe seen in IDLE is ignored.

Operands that come from architectural state are read at execute time, not when the instruction is staged. These are the data latch, the current outer loop count and the flags.

Top module: `dk_regupd`

## Requirements
- R1: After reset, olc, ilc, ilc_inf, tapl, dl, flag_a and flag_b are all zero and nothing is staged.
- R2: An operation takes effect on the registers in the clock edge where exec_stb is sampled high, using the instruction fields sampled at its on-deck edge. Changes to the instruction inputs after that edge have no effect.
- R3: With a set instruction (ins_shift=0) and ins_dst=000, src 00 loads olc from the payload ins_imm[13:0], src 01 loads it from dl[13:0], and src 10 loads olc-1, which stays at 0 when olc is 0.
- R4: With ins_dst=001, src 00 loads ilc from the payload and src 01 loads it from dl[13:0]; both clear ilc_inf. Src 10 sets ilc_inf to 1 and leaves ilc unchanged.
- R5: Src 00 with ins_dst=010 loads tapl from payload bits [10:0].
- R6: With ins_dst=100, src 01 loads dl with the payload zero-extended to 37 bits, and src 10 loads it with the payload extended by ones.
- R7: ins_dst=111 with any src updates both flags at once. New A is nextA[idx] and new B is nextB[idx], where nextA=payload[11:6], nextB=payload[5:0] and idx=4*A+2*B+C. A and B are the flag values before the update and C is c_flag in the execute cycle. Index values 6 and 7 give 0.
- R8: A shift instruction (ins_shift=1) sets dl to {dl[17:0], ins_imm[18:0]}.
- R9: Every set src/dst pair not listed in R3 to R7 leaves all outputs unchanged.
- R10: exec_stb with nothing staged has no effect, and a staged operation is applied only once.
- R11: When deck_stb and exec_stb are high in the same cycle, the previously staged operation is applied and the new instruction is staged for the next exec_stb. An operand read by the new instruction sees the value written by the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deck_stb | input | 1 | Instruction comes on deck: decode and stage it |
| exec_stb | input | 1 | Staged instruction executes |
| ins_shift | input | 1 | 1 = shift instruction, 0 = set instruction |
| ins_src | input | 2 | Set source selector |
| ins_dst | input | 3 | Set destination selector |
| ins_imm | input | 19 | Shift literal; low 14 bits are the set payload |
| c_flag | input | 1 | Current control flag C |
| olc | output | 14 | Outer loop counter |
| ilc | output | 14 | Inner loop counter value |
| ilc_inf | output | 1 | Inner loop counter holds infinity |
| tapl | output | 11 | Torpedo acknowledgment path latch |
| dl | output | 37 | Data latch |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |

## Verification
Staging a new instruction and executing the old one can fall in the same cycle. The bench provokes this by raising deck_stb and exec_stb together. It first checks that the registers show only the old operation, then fires again and checks that the new one lands. In a second case the old operation writes the data latch and the new one loads the outer loop counter from the data latch. The counter must receive the freshly written value, not the value present at staging.

// File: rtl/dk_pkg.sv
package dk_pkg;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_OLC_PAY,
        OP_OLC_DL,
        OP_OLC_DEC,
        OP_ILC_PAY,
        OP_ILC_DL,
        OP_ILC_INF,
        OP_TAPL,
        OP_DL_LIT,
        OP_FLAGS,
        OP_SHIFT
    } op_e;

    typedef enum logic {
        ST_IDLE,
        ST_ARMED
    } stage_e;

endpackage

// File: rtl/dk_decode.sv
module dk_decode
    import dk_pkg::*;
#(
    parameter int DL_W  = 37,
    parameter int PAY_W = 14,
    parameter int SHL_W = 19
) (
    input  logic             shift,
    input  logic [1:0]       src,
    input  logic [2:0]       dst,
    input  logic [SHL_W-1:0] imm,
    output op_e              op,
    output logic [DL_W-1:0]  lit
);
    localparam int EXT_W = DL_W - PAY_W;
    localparam int SPAD  = DL_W - SHL_W;

    logic [PAY_W-1:0] pay;
    assign pay = imm[PAY_W-1:0];

    always_comb begin
        op  = OP_NOP;
        lit = {{EXT_W{1'b0}}, pay};
        if (shift) begin
            op  = OP_SHIFT;
            lit = {{SPAD{1'b0}}, imm};
        end else begin
            unique case (dst)
                3'b000: begin
                    unique case (src)
                        2'b00:   op = OP_OLC_PAY;
                        2'b01:   op = OP_OLC_DL;
                        2'b10:   op = OP_OLC_DEC;
                        default: op = OP_NOP;
                    endcase
                end
                3'b001: begin
                    unique case (src)
                        2'b00:   op = OP_ILC_PAY;
                        2'b01:   op = OP_ILC_DL;
                        2'b10:   op = OP_ILC_INF;
                        default: op = OP_NOP;
                    endcase
                end
                3'b010: op = (src == 2'b00) ? OP_TAPL : OP_NOP;
                3'b100: begin
                    unique case (src)
                        2'b01:   op = OP_DL_LIT;
                        2'b10: begin
                            op  = OP_DL_LIT;
                            lit = {{EXT_W{1'b1}}, pay};
                        end
                        default: op = OP_NOP;
                    endcase
                end
                3'b111:  op = OP_FLAGS;
                default: op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/dk_stage.sv
module dk_stage
    import dk_pkg::*;
#(
    parameter int DL_W = 37
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            deck,
    input  logic            exec,
    input  op_e             op_in,
    input  logic [DL_W-1:0] lit_in,
    output op_e             op_q,
    output logic [DL_W-1:0] lit_q,
    output logic            armed,
    output logic            fire
);
    stage_e state, state_nx;

    // transitions: LOAD, FIRE, FIRE_LOAD, RELOAD
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (deck) state_nx = ST_ARMED;
            ST_ARMED: if (exec && !deck) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_NOP;
            lit_q <= '0;
        end else begin
            state <= state_nx;
            if (deck) begin
                op_q  <= op_in;
                lit_q <= lit_in;
            end
        end
    end

    always_comb begin
        armed = (state == ST_ARMED);
        fire  = armed && exec;
    end

    p_arm_after_deck_r2: assert property (@(posedge clk) disable iff (!rst_n)
        deck |=> (state == ST_ARMED));

    p_consumed_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !deck) |=> (state == ST_IDLE));
endmodule

// File: rtl/dk_flag_lut.sv
module dk_flag_lut #(
    parameter int TT_W = 6
) (
    input  logic [TT_W-1:0] table_in,
    input  logic            a,
    input  logic            b,
    input  logic            c,
    output logic            nxt
);
    localparam int IDX_N = 8;

    logic [IDX_N-1:0] padded;
    logic [2:0]       idx;

    generate
        if (TT_W < IDX_N) begin : g_pad
            assign padded = {{(IDX_N-TT_W){1'b0}}, table_in};
        end else begin : g_full
            assign padded = table_in[IDX_N-1:0];
        end
    endgenerate

    assign idx = {a, b, c};
    assign nxt = padded[idx];
endmodule

// File: rtl/dk_regupd.sv
module dk_regupd
    import dk_pkg::*;
#(
    parameter int DL_W   = 37,
    parameter int PAY_W  = 14,
    parameter int SHL_W  = 19,
    parameter int CNT_W  = 14,
    parameter int PATH_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deck_stb,
    input  logic              exec_stb,
    input  logic              ins_shift,
    input  logic [1:0]        ins_src,
    input  logic [2:0]        ins_dst,
    input  logic [SHL_W-1:0]  ins_imm,
    input  logic              c_flag,
    output logic [CNT_W-1:0]  olc,
    output logic [CNT_W-1:0]  ilc,
    output logic              ilc_inf,
    output logic [PATH_W-1:0] tapl,
    output logic [DL_W-1:0]   dl,
    output logic              flag_a,
    output logic              flag_b
);
    localparam int TT_W   = (PAY_W - 2) / 2;
    localparam int KEEP_W = DL_W - SHL_W;

    op_e             dec_op, op_q;
    logic [DL_W-1:0] dec_lit, lit_q;
    logic            armed, fire;
    logic            nxt_a, nxt_b;

    dk_decode #(.DL_W(DL_W), .PAY_W(PAY_W), .SHL_W(SHL_W)) u_dec (
        .shift (ins_shift),
        .src   (ins_src),
        .dst   (ins_dst),
        .imm   (ins_imm),
        .op    (dec_op),
        .lit   (dec_lit)
    );

    dk_stage #(.DL_W(DL_W)) u_stg (
        .clk    (clk),
        .rst_n  (rst_n),
        .deck   (deck_stb),
        .exec   (exec_stb),
        .op_in  (dec_op),
        .lit_in (dec_lit),
        .op_q   (op_q),
        .lit_q  (lit_q),
        .armed  (armed),
        .fire   (fire)
    );

    dk_flag_lut #(.TT_W(TT_W)) u_lut_a (
        .table_in (lit_q[2*TT_W-1:TT_W]),
        .a        (flag_a),
        .b        (flag_b),
        .c        (c_flag),
        .nxt      (nxt_a)
    );

    dk_flag_lut #(.TT_W(TT_W)) u_lut_b (
        .table_in (lit_q[TT_W-1:0]),
        .a        (flag_a),
        .b        (flag_b),
        .c        (c_flag),
        .nxt      (nxt_b)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            olc     <= '0;
            ilc     <= '0;
            ilc_inf <= 1'b0;
            tapl    <= '0;
            dl      <= '0;
            flag_a  <= 1'b0;
            flag_b  <= 1'b0;
        end else if (fire) begin
            unique case (op_q)
                OP_OLC_PAY: olc <= lit_q[CNT_W-1:0];
                OP_OLC_DL:  olc <= dl[CNT_W-1:0];
                OP_OLC_DEC: olc <= (olc == '0) ? '0 : olc - CNT_W'(1);
                OP_ILC_PAY: begin
                    ilc     <= lit_q[CNT_W-1:0];
                    ilc_inf <= 1'b0;
                end
                OP_ILC_DL: begin
                    ilc     <= dl[CNT_W-1:0];
                    ilc_inf <= 1'b0;
                end
                OP_ILC_INF: ilc_inf <= 1'b1;
                OP_TAPL:    tapl <= lit_q[PATH_W-1:0];
                OP_DL_LIT:  dl <= lit_q;
                OP_SHIFT:   dl <= {dl[KEEP_W-1:0], lit_q[SHL_W-1:0]};
                OP_FLAGS: begin
                    flag_a <= nxt_a;
                    flag_b <= nxt_b;
                end
                default: ;
            endcase
        end
    end

    p_idle_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && !armed) |=> ($stable(olc) && $stable(ilc) && $stable(ilc_inf)
                                  && $stable(tapl) && $stable(dl)
                                  && $stable(flag_a) && $stable(flag_b)));

    p_dec_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_q == OP_OLC_DEC && olc == '0) |=> (olc == '0));

    p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_q == OP_OLC_DEC && olc != '0) |=> (olc == $past(olc) - CNT_W'(1)));

    p_inf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_q == OP_ILC_INF) |=> ilc_inf);

    p_shift_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_q == OP_SHIFT) |=> (dl[SHL_W-1:0] == $past(lit_q[SHL_W-1:0])));
endmodule

// File: tb/sim_dk_regupd.sv
module sim_dk_regupd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deck_stb = 1'b0, exec_stb = 1'b0;
    logic        ins_shift = 1'b0;
    logic [1:0]  ins_src = '0;
    logic [2:0]  ins_dst = '0;
    logic [18:0] ins_imm = '0;
    logic        c_flag = 1'b0;
    logic [13:0] olc, ilc;
    logic        ilc_inf;
    logic [10:0] tapl;
    logic [36:0] dl;
    logic        flag_a, flag_b;

    int checks = 0, errors = 0;

    logic [13:0] e_olc = '0, e_ilc = '0;
    logic        e_inf = 1'b0;
    logic [10:0] e_tapl = '0;
    logic [36:0] e_dl = '0;
    logic        e_a = 1'b0, e_b = 1'b0;

    always #2 clk = ~clk;

    dk_regupd u0 (
        .clk(clk), .rst_n(rst_n), .deck_stb(deck_stb), .exec_stb(exec_stb),
        .ins_shift(ins_shift), .ins_src(ins_src), .ins_dst(ins_dst),
        .ins_imm(ins_imm), .c_flag(c_flag), .olc(olc), .ilc(ilc),
        .ilc_inf(ilc_inf), .tapl(tapl), .dl(dl), .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " olc"}, 64'(olc), 64'(e_olc));
        chk({tag, " ilc"}, 64'(ilc), 64'(e_ilc));
        chk({tag, " ilc_inf"}, 64'(ilc_inf), 64'(e_inf));
        chk({tag, " tapl"}, 64'(tapl), 64'(e_tapl));
        chk({tag, " dl"}, 64'(dl), 64'(e_dl));
        chk({tag, " flag_a"}, 64'(flag_a), 64'(e_a));
        chk({tag, " flag_b"}, 64'(flag_b), 64'(e_b));
    endtask

    task automatic put(input logic sh, input logic [1:0] s, input logic [2:0] d,
                       input logic [18:0] imm);
        ins_shift = sh; ins_src = s; ins_dst = d; ins_imm = imm;
    endtask

    task automatic deck(input logic sh, input logic [1:0] s, input logic [2:0] d,
                        input logic [18:0] imm);
        @(negedge clk);
        put(sh, s, d, imm);
        deck_stb = 1'b1;
        @(negedge clk);
        deck_stb = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk);
        exec_stb = 1'b1;
        @(negedge clk);
        exec_stb = 1'b0;
    endtask

    task automatic run(input logic sh, input logic [1:0] s, input logic [2:0] d,
                       input logic [18:0] imm);
        deck(sh, s, d, imm);
        fire();
    endtask

    task automatic both(input logic sh, input logic [1:0] s, input logic [2:0] d,
                        input logic [18:0] imm);
        @(negedge clk);
        put(sh, s, d, imm);
        deck_stb = 1'b1;
        exec_stb = 1'b1;
        @(negedge clk);
        deck_stb = 1'b0;
        exec_stb = 1'b0;
    endtask

    function automatic logic [18:0] fpay(input logic [5:0] na, input logic [5:0] nb);
        return {7'b0, na, nb};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");
        fire();
        chk_all("R1 nothing staged after reset");
    endtask

    task automatic t_olc();
        run(0, 2'b00, 3'b000, 19'h00005); e_olc = 14'd5;
        chk_all("R3 olc from payload");
        run(0, 2'b10, 3'b000, 19'h0); e_olc = 14'd4;
        chk_all("R3 olc minus one");
        run(0, 2'b01, 3'b100, 19'h02A3C); e_dl = 37'h2A3C;
        chk_all("R6 zero-extended literal");
        run(0, 2'b01, 3'b000, 19'h0); e_olc = 14'h2A3C;
        chk_all("R3 olc from data latch");
        run(0, 2'b00, 3'b000, 19'h0); e_olc = 14'd0;
        run(0, 2'b10, 3'b000, 19'h0);
        chk_all("R3 olc minus one floors at zero");
    endtask

    task automatic t_ilc();
        run(0, 2'b00, 3'b001, 19'h00007); e_ilc = 14'd7;
        chk_all("R4 ilc from payload");
        run(0, 2'b10, 3'b001, 19'h0); e_inf = 1'b1;
        chk_all("R4 ilc infinity");
        run(0, 2'b01, 3'b001, 19'h0); e_ilc = 14'h2A3C; e_inf = 1'b0;
        chk_all("R4 ilc from data latch clears infinity");
        run(0, 2'b10, 3'b001, 19'h0); e_inf = 1'b1;
        run(0, 2'b00, 3'b001, 19'h00003); e_ilc = 14'd3; e_inf = 1'b0;
        chk_all("R4 ilc payload clears infinity");
    endtask

    task automatic t_tapl();
        run(0, 2'b00, 3'b010, 19'h03ABC); e_tapl = 11'h2BC;
        chk_all("R5 tapl from payload");
    endtask

    task automatic t_dlit();
        run(0, 2'b10, 3'b100, 19'h00123); e_dl = {{23{1'b1}}, 14'h0123};
        chk_all("R6 one-extended literal");
        run(0, 2'b01, 3'b100, 19'h03FFF); e_dl = {23'b0, 14'h3FFF};
        chk_all("R6 zero-extended all-ones payload");
    endtask

    task automatic t_shift();
        run(1, 2'b11, 3'b111, 19'h5A5A5); e_dl = {e_dl[17:0], 19'h5A5A5};
        chk_all("R8 shift one");
        run(1, 2'b00, 3'b000, 19'h7FFFF); e_dl = {e_dl[17:0], 19'h7FFFF};
        chk_all("R8 shift two");
    endtask

    task automatic t_flags();
        c_flag = 1'b0;
        run(0, 2'b00, 3'b111, fpay(6'b000001, 6'b000000)); e_a = 1'b1; e_b = 1'b0;
        chk_all("R7 flags index 0");
        deck(0, 2'b11, 3'b111, fpay(6'b011111, 6'b100000));
        c_flag = 1'b1;
        fire(); e_a = 1'b0; e_b = 1'b1;
        chk_all("R7 flags index 5 with C read at execute");
        c_flag = 1'b0;
        run(0, 2'b01, 3'b111, fpay(6'b000100, 6'b000100)); e_a = 1'b1; e_b = 1'b1;
        chk_all("R7 flags index 2");
        run(0, 2'b10, 3'b111, fpay(6'b111111, 6'b111111)); e_a = 1'b0; e_b = 1'b0;
        chk_all("R7 flags index 6 gives zero");
    endtask

    task automatic t_nop();
        run(0, 2'b11, 3'b000, 19'h01111); chk_all("R9 src11 dst000");
        run(0, 2'b11, 3'b001, 19'h01111); chk_all("R9 src11 dst001");
        run(0, 2'b01, 3'b010, 19'h01111); chk_all("R9 src01 dst010");
        run(0, 2'b00, 3'b100, 19'h01111); chk_all("R9 src00 dst100");
        run(0, 2'b01, 3'b011, 19'h01111); chk_all("R9 dst011");
        run(0, 2'b10, 3'b101, 19'h01111); chk_all("R9 dst101");
        run(0, 2'b00, 3'b110, 19'h01111); chk_all("R9 dst110");
    endtask

    task automatic t_idle();
        run(0, 2'b00, 3'b000, 19'h00009); e_olc = 14'd9;
        fire();
        chk_all("R10 exec with nothing staged");
        run(0, 2'b10, 3'b000, 19'h0); e_olc = 14'd8;
        fire();
        chk_all("R10 staged op applied once");
    endtask

    task automatic t_overlap();
        deck(0, 2'b00, 3'b000, 19'h00011);
        put(0, 2'b00, 3'b000, 19'h00022);
        fire(); e_olc = 14'h11;
        chk_all("R2 inputs after deck ignored");
        deck(0, 2'b00, 3'b000, 19'h00009);
        both(0, 2'b00, 3'b000, 19'h00003); e_olc = 14'd9;
        chk_all("R11 same-cycle exec applies old op");
        fire(); e_olc = 14'd3;
        chk_all("R11 new op applied on next exec");
        deck(0, 2'b01, 3'b100, 19'h01234);
        both(0, 2'b01, 3'b000, 19'h0); e_dl = 37'h1234;
        chk_all("R11 data write in overlap cycle");
        fire(); e_olc = 14'h1234;
        chk_all("R11 R2 operand read at execute");
    endtask

    initial begin
        t_reset();
        t_olc();
        t_ilc();
        t_tapl();
        t_dlit();
        t_shift();
        t_flags();
        t_nop();
        t_idle();
        t_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule